// File: doc/BRIEF.md
# Phase-Aligned Multi-Output Clock Divider

This block derives several divided clocks from one reference clock. Each output lane runs its own integer divider. Software writes a new divide value for a lane into a pending register, and the lane keeps its current rate while the value waits there. The new values take effect together only when a commit command is written. The commit command starts a re-phase sequence.

During the re-phase sequence, each lane that is selected in the align mask finishes its current high phase and then parks low. When every selected lane is parked low, all of them load their pending divide values on the same reference edge and start high together. Lanes that are not selected keep running at their old rate and keep their old phase. A busy status bit is set for the whole sequence and clears by itself at the restart edge. A change flag per lane records that a pending value differs from the one it replaced.

The register port has no data stream, so it carries no valid/ready handshake. A write is a single-cycle strobe with an address and data. A read is a combinational mux that follows the read address.

Top module: `clkdiv_align_ctrl`

## Requirements
- R1: Writing a lane's pending divide value (lanes at addresses 0 to 3, value in data bits 4:0) does not change that lane's output period or phase until a commit.
- R2: A write to address 5 with data bit 0 set, while not busy, starts a re-phase sequence. The busy output and bit 0 of the status register at address 6 read 1 from the next cycle on.
- R3: Busy returns to 0 by itself on the same edge on which the selected lanes restart.
- R4: While busy, a selected lane that is high completes its high phase, then stays low until the restart. On the last busy cycle every selected lane is low.
- R5: All selected lanes go high on the same reference edge at the restart, even when their divide value did not change.
- R6: After restart, a lane with value r divides by D = r+1 (r = 0 is treated as D = 2). It is high for floor(D/2) reference cycles and low for the rest.
- R7: A lane that is clear in the align mask (address 4, bit i for lane i) keeps its old divide value and keeps running through a sequence.
- R8: The change flags at address 7 (bit i for lane i) set when a write to a lane gives a value that differs from its pending value. The flags of selected lanes clear at the restart. The flags of lanes that were not selected stay set.
- R9: A commit write while busy is ignored. The sequence ends normally, and busy then stays 0.
- R10: After reset, busy is 0, the change flags are 0, the align mask is all ones, and every pending value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sysclk | output | 4 | Divided clock outputs, one per lane |
| go_busy | output | 1 | High while a re-phase sequence is in progress |

## Verification
Several kinds of internal fault are visible at the ports:
- A lane counter or latched mask that is wrong shows up within one divided period as a wrong high or low phase length.
- A lane that parks in the wrong state shows up in the sample taken on the last busy cycle or at the restart edge: a selected output is high before the restart, or the selected outputs do not rise together.
- A sequencer stuck busy appears as a status bit that never falls.
- Stale change flags show up in the first status read after the restart.

Unselected lanes are measured after the sequence, so an accidental reload of such a lane shows up as a changed period within a few dozen cycles.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // effective divide for a stored value: value+1, with 0 promoted to 2
  function automatic int unsigned eff_div(input int unsigned v);
    return (v == 0) ? 2 : v + 1;
  endfunction
endpackage

// File: rtl/cdiv_lane.sv
`timescale 1ns/1ps
module cdiv_lane #(
  parameter int RATIO_W   = 5,
  parameter int RST_RATIO = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               out_o
);
  localparam int CNT_W = RATIO_W + 1;

  logic [RATIO_W-1:0] act_q;
  logic [CNT_W-1:0]   cnt_q, cnt_nx, div, term, half;
  logic               out_q;

  always_comb begin
    div  = (act_q == '0) ? CNT_W'(2) : CNT_W'(act_q) + CNT_W'(1);
    term = div - CNT_W'(1);
    half = div >> 1;
    cnt_nx = (cnt_q >= term) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RATIO_W'(RST_RATIO);
      cnt_q <= '1;
      out_q <= 1'b0;
    end else if (load_i) begin
      act_q <= ratio_i;
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (hold_i && !out_q) begin
      cnt_q <= cnt_q;
    end else begin
      cnt_q <= cnt_nx;
      out_q <= (cnt_nx < half);
    end
  end

  assign out_o = out_q;

  // R4
  parked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !out_q && !load_i) |=> !out_q);
  // R5
  restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> out_q);
  // R1
  ratio_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(act_q));
endmodule

// File: rtl/cdiv_go_seq.sv
`timescale 1ns/1ps
module cdiv_go_seq #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_req,
  input  logic [NUM_OUT-1:0] align_i,
  input  logic [NUM_OUT-1:0] lane_lvl,
  output logic               busy_o,
  output logic [NUM_OUT-1:0] hold_o,
  output logic [NUM_OUT-1:0] load_o
);
  logic [NUM_OUT-1:0] mask_q;
  logic               busy_q, all_low, release_now;

  assign all_low     = &(~mask_q | ~lane_lvl);
  assign release_now = busy_q && all_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mask_q <= '0;
    end else if (!busy_q && go_req) begin
      busy_q <= 1'b1;
      mask_q <= align_i;
    end else if (release_now) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign hold_o = busy_q ? mask_q : '0;
  assign load_o = release_now ? mask_q : '0;

  // R2
  go_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && go_req) |=> busy_q);
  // R3
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && all_low) |=> !busy_q);
  // R9
  mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(mask_q));
endmodule

// File: rtl/clkdiv_align_ctrl.sv
`timescale 1ns/1ps
module clkdiv_align_ctrl #(
  parameter int NUM_OUT   = 4,
  parameter int RATIO_W   = 5,
  parameter int DATA_W    = 8,
  parameter int RST_RATIO = 1,
  parameter int ADDR_W    = $clog2(NUM_OUT + 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_OUT-1:0] sysclk,
  output logic               go_busy
);
  localparam logic [ADDR_W-1:0] A_ALIGN = ADDR_W'(NUM_OUT);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(NUM_OUT + 1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(NUM_OUT + 2);
  localparam logic [ADDR_W-1:0] A_CHG   = ADDR_W'(NUM_OUT + 3);

  logic [RATIO_W-1:0] pend_q [NUM_OUT];
  logic [NUM_OUT-1:0] align_q, chg_q, hold, load, chg_set;
  logic               go_req;

  assign go_req = wr_en && (wr_addr == A_CMD) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) align_q <= '1;
    else if (wr_en && wr_addr == A_ALIGN) align_q <= wr_data[NUM_OUT-1:0];
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    assign chg_set[i] = wr_en && (wr_addr == ADDR_W'(i)) &&
                        (wr_data[RATIO_W-1:0] != pend_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= RATIO_W'(RST_RATIO);
        chg_q[i]  <= 1'b0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(i)) pend_q[i] <= wr_data[RATIO_W-1:0];
        if (chg_set[i])   chg_q[i] <= 1'b1;
        else if (load[i]) chg_q[i] <= 1'b0;
      end
    end

    cdiv_lane #(.RATIO_W(RATIO_W), .RST_RATIO(RST_RATIO)) u_lane (
      .clk(clk), .rst_n(rst_n), .hold_i(hold[i]), .load_i(load[i]),
      .ratio_i(pend_q[i]), .out_o(sysclk[i])
    );

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load[i] && !chg_set[i]) |=> !chg_q[i]);
    // R7
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold[i]) |-> !load[i]);
  end

  cdiv_go_seq #(.NUM_OUT(NUM_OUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .align_i(align_q),
    .lane_lvl(sysclk), .busy_o(go_busy), .hold_o(hold), .load_o(load)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_OUT; i++)
      if (rd_addr == ADDR_W'(i)) rd_data[RATIO_W-1:0] = pend_q[i];
    if (rd_addr == A_ALIGN) rd_data[NUM_OUT-1:0] = align_q;
    if (rd_addr == A_STAT)  rd_data[0] = go_busy;
    if (rd_addr == A_CHG)   rd_data[NUM_OUT-1:0] = chg_q;
  end
endmodule

// File: tb/tb_clkdiv_align_ctrl.sv
`timescale 1ns/1ps
module tb_clkdiv_align_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] sysclk;
  logic       go_busy;

  int vec = 0, bad = 0;
  int pend [4] = '{1, 1, 1, 1};
  bit done = 0;

  // lane at [7:6], divide value at [4:0]
  localparam logic [7:0] VEC [0:5] = '{8'h03, 8'h44, 8'h80, 8'hC6, 8'h1F, 8'h41};

  clkdiv_align_ctrl dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rreg(input int a, output int d);
    rd_addr = 3'(a);
    #0.5;
    d = int'(rd_data);
  endtask

  task automatic measure(input int ln, output int hi, output int lo);
    int t = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    while (sysclk[ln] !== 1'b0 && t < 200) begin @(negedge clk); t++; end
    while (sysclk[ln] !== 1'b1 && t < 200) begin @(negedge clk); t++; end
    while (sysclk[ln] === 1'b1 && t < 400) begin hi++; @(negedge clk); t++; end
    while (sysclk[ln] === 1'b0 && t < 400) begin lo++; @(negedge clk); t++; end
  endtask

  task automatic run_go(input logic [3:0] mask);
    logic [3:0] prev;
    int t = 0, s;
    wreg(5, 1);
    rreg(6, s);
    chk("R2 status busy", s & 1, 1);
    prev = sysclk;
    while (go_busy === 1'b1 && t < 300) begin prev = sysclk; @(negedge clk); t++; end
    chk("R3 busy self-clears", int'(go_busy), 0);
    chk("R4 selected low before restart", int'(prev & mask), 0);
    chk("R5 selected rise together", int'(sysclk & mask), int'(mask));
  endtask

  function automatic int dv(input int r);
    return (r == 0) ? 2 : r + 1;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    int d, hi, lo, ln, r, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(go_busy), 0);
    rreg(7, d); chk("R10 change flags", d, 0);
    rreg(4, d); chk("R10 align mask", d, 15);
    rreg(0, d); chk("R10 pending lane0", d, 1);
    measure(0, hi, lo);
    chk("R6 reset high", hi, 1); chk("R6 reset low", lo, 1);

    for (int k = 0; k < 6; k++) begin
      ln = int'(VEC[k][7:6]);
      r  = int'(VEC[k][4:0]);
      wreg(ln, r);
      rreg(7, d);
      chk("R8 flag set", (d >> ln) & 1, (r != pend[ln]) ? 1 : 0);
      pend[ln] = r;
      run_go(4'hF);
      rreg(7, d); chk("R8 flags cleared", d, 0);
      measure(ln, hi, lo);
      chk("R6 high phase", hi, dv(r) / 2);
      chk("R6 low phase", lo, dv(r) - dv(r) / 2);
    end

    // R1: pending value on lane 2 does not act before commit
    wreg(2, 5);
    measure(2, hi, lo);
    chk("R1 high before commit", hi, 1); chk("R1 low before commit", lo, 1);

    // R7: lane 2 unselected keeps old rate, flag stays
    wreg(4, 3);
    run_go(4'h3);
    measure(2, hi, lo);
    chk("R7 unselected high", hi, 1); chk("R7 unselected low", lo, 1);
    rreg(7, d); chk("R8 unselected flag kept", (d >> 2) & 1, 1);

    // R5: unchanged values still realigned
    wreg(2, 1); pend[2] = 1;
    wreg(4, 15);
    run_go(4'hF);

    // R9: commit during busy ignored
    wreg(4, 1);
    wreg(5, 1);
    wreg(5, 1);
    t = 0;
    while (go_busy === 1'b1 && t < 300) begin @(negedge clk); t++; end
    d = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); if (go_busy !== 1'b0) d++; end
    chk("R9 busy stays low", d, 0);
    measure(0, hi, lo);
    chk("R9 lane0 high", hi, 16); chk("R9 lane0 low", lo, 16);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule